// File: doc/BRIEF.md
# External Memory Bus Controller

This controller takes one 16-bit word access at a time from an internal requester and performs it on a slow asynchronous memory bus. The word address is matched against four programmable address windows. The matching window drives its own active-low chip select. That window's configuration sets the number of wait states, which differs for reads and writes. It also sets how the access finishes: on the count, on an external acknowledge, on both, or on whichever comes first.

All bus phases advance on an interface tick. The tick is the core clock divided by 1, 2, 4, 16 or 32. Each access runs through four phases: a setup phase with the select asserted, a strobe phase, a hold phase with the strobe released, and a return to idle. The bus can be 16 bits wide or 8 bits wide. On an 8-bit bus, each word is split into two byte accesses and rebuilt internally. The active level of the read strobe and the write strobe can each be set.

Top module: `ext_bus_ctrl`

## Requirements
- R1: A word address selects window i when lo_i <= addr <= hi_i, both bounds inclusive. When windows overlap, the lowest index wins. Select `mem_sel_n[i]` is low from setup through hold, and at most one select is ever low.
- R2: An address in no window asserts no select and no strobe. It responds one interface tick after acceptance, with `rsp_err`=1 and `rsp_rdata`=0.
- R3: In completion mode 00 (count only), the strobe lasts W+1 interface ticks. W is the window's read wait field for reads and its write wait field for writes. The acknowledge input has no effect in this mode.
- R4: Completion mode is a 2-bit field per window: 01 = acknowledge only, 10 = count elapsed and acknowledge high, 11 = count elapsed or acknowledge high. The acknowledge input is sampled on interface ticks during the strobe.
- R5: `cfg_div` codes 0, 1, 2, 3 and 4 give an interface tick every 1, 2, 4, 16 and 32 core cycles. All bus phases advance only on a tick.
- R6: With `cfg_bus8`=0, `mem_addr` carries the word address with bit 16 at zero. A read returns all 16 bits of `mem_din`, and a write drives the whole word on `mem_dout`.
- R7: With `cfg_bus8`=1, each word takes two byte accesses on lane [7:0]. The low byte goes first at byte address {addr,0}, then the high byte at {addr,1}. Exactly one response follows the second byte.
- R8: `cfg_rd_pol` and `cfg_wr_pol` give the active level of `mem_rd` and `mem_wr`. Each strobe sits at the inverse of its active level when not strobing, and the two strobes are never active together.
- R9: `req_ready` is high only when the controller is idle and on an interface tick. Only one access is outstanding at a time. `rsp_valid` is a single-cycle pulse.
- R10: While reset is held, all selects are high, both strobes are at their inactive level and `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | core clock |
| rst_n | input | 1 | active-low asynchronous reset |
| req_valid | input | 1 | access request valid |
| req_ready | output | 1 | request accepted this cycle when valid |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | word address |
| req_wdata | input | 16 | write data |
| rsp_valid | output | 1 | one-cycle completion pulse |
| rsp_rdata | output | 16 | read data (zero for writes and misses) |
| rsp_err | output | 1 | address matched no window |
| cfg_lo | input | NB*AW | per-window inclusive lower bound |
| cfg_hi | input | NB*AW | per-window inclusive upper bound |
| cfg_rd_wait | input | NB*WW | per-window read wait count |
| cfg_wr_wait | input | NB*WW | per-window write wait count |
| cfg_mode | input | NB*2 | per-window completion mode |
| cfg_div | input | 3 | interface clock ratio code |
| cfg_bus8 | input | 1 | 1 = 8-bit external bus |
| cfg_rd_pol | input | 1 | active level of read strobe |
| cfg_wr_pol | input | 1 | active level of write strobe |
| mem_sel_n | output | NB | active-low window selects |
| mem_addr | output | AW+1 | external address (byte address in 8-bit mode) |
| mem_rd | output | 1 | read strobe |
| mem_wr | output | 1 | write strobe |
| mem_oe | output | 1 | data bus drive enable during writes |
| mem_dout | output | 16 | write data to bus |
| mem_din | input | 16 | read data from bus |
| mem_ack | input | 1 | external acknowledge |

## Verification
The bench holds acknowledge high early in a count-only window. A design that listens to it there ends the strobe too soon and shows a shorter latency. Acknowledge arrives both before and after the count expires in the AND and OR windows, so swapped mode encodings give the wrong latency. An address inside two overlapping windows must pick the lower one; a reversed priority shows up as the wrong select. In 8-bit mode the bench checks the order of the byte addresses, the lane data and the single response. Each of the five divider ratios and both strobe polarities are run, so a wrong ratio stretches or shrinks the latency, and an inverted strobe is never seen as a strobe.

// File: rtl/ext_bus_ctrl.sv
module ext_bus_ctrl #(
  parameter int AW = 16,
  parameter int WW = 4,
  parameter int NB = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_we,
  input  logic [AW-1:0]    req_addr,
  input  logic [15:0]      req_wdata,
  output logic             rsp_valid,
  output logic [15:0]      rsp_rdata,
  output logic             rsp_err,
  input  logic [NB*AW-1:0] cfg_lo,
  input  logic [NB*AW-1:0] cfg_hi,
  input  logic [NB*WW-1:0] cfg_rd_wait,
  input  logic [NB*WW-1:0] cfg_wr_wait,
  input  logic [NB*2-1:0]  cfg_mode,
  input  logic [2:0]       cfg_div,
  input  logic             cfg_bus8,
  input  logic             cfg_rd_pol,
  input  logic             cfg_wr_pol,
  output logic [NB-1:0]    mem_sel_n,
  output logic [AW:0]      mem_addr,
  output logic             mem_rd,
  output logic             mem_wr,
  output logic             mem_oe,
  output logic [15:0]      mem_dout,
  input  logic [15:0]      mem_din,
  input  logic             mem_ack
);
  localparam int BW = (NB > 1) ? $clog2(NB) : 1;

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_STROBE, S_HOLD, S_MISS} st_t;
  st_t state;

  logic [5:0] dcnt, ratio;
  logic tick;
  always_comb
    case (cfg_div)
      3'd1: ratio = 6'd2;
      3'd2: ratio = 6'd4;
      3'd3: ratio = 6'd16;
      3'd4: ratio = 6'd32;
      default: ratio = 6'd1;
    endcase
  assign tick = (dcnt >= ratio - 6'd1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) dcnt <= '0;
    else dcnt <= tick ? 6'd0 : dcnt + 6'd1;

  logic hit;
  logic [BW-1:0] hit_idx;
  always_comb begin
    hit = 1'b0;
    hit_idx = '0;
    for (int i = NB - 1; i >= 0; i--)
      if (req_addr >= cfg_lo[i*AW +: AW] && req_addr <= cfg_hi[i*AW +: AW]) begin
        hit = 1'b1;
        hit_idx = BW'(i);
      end
  end

  logic [AW-1:0] addr_q;
  logic [15:0]   wdata_q, rdata_q;
  logic [BW-1:0] bank_q;
  logic [WW-1:0] wcnt, wload;
  logic [1:0]    mode;
  logic          we_q, byte_q, done, busy;

  assign wload = we_q ? cfg_wr_wait[bank_q*WW +: WW] : cfg_rd_wait[bank_q*WW +: WW];
  assign mode  = cfg_mode[bank_q*2 +: 2];

  always_comb
    case (mode)
      2'b00: done = (wcnt == '0);
      2'b01: done = mem_ack;
      2'b10: done = (wcnt == '0) && mem_ack;
      default: done = (wcnt == '0) || mem_ack;
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state <= S_IDLE; addr_q <= '0; wdata_q <= '0; rdata_q <= '0; bank_q <= '0;
      wcnt <= '0; we_q <= 1'b0; byte_q <= 1'b0; rsp_valid <= 1'b0; rsp_err <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      if (tick)
        case (state)
          S_IDLE: if (req_valid) begin
            addr_q <= req_addr; wdata_q <= req_wdata; we_q <= req_we; bank_q <= hit_idx;
            byte_q <= 1'b0; rdata_q <= '0; rsp_err <= 1'b0;
            state <= hit ? S_SETUP : S_MISS;
          end
          S_SETUP: begin
            wcnt  <= wload;
            state <= S_STROBE;
          end
          S_STROBE: if (done) begin
            state <= S_HOLD;
            if (!we_q) begin
              if (!cfg_bus8)  rdata_q <= mem_din;
              else if (byte_q) rdata_q[15:8] <= mem_din[7:0];
              else rdata_q[7:0] <= mem_din[7:0];
            end
          end else if (wcnt != '0) wcnt <= wcnt - 1'b1;
          S_HOLD: if (cfg_bus8 && !byte_q) begin
            byte_q <= 1'b1;
            state  <= S_SETUP;
          end else begin
            state <= S_IDLE;
            rsp_valid <= 1'b1;
          end
          default: begin
            state <= S_IDLE;
            rsp_valid <= 1'b1;
            rsp_err <= 1'b1;
          end
        endcase
    end

  assign busy      = (state == S_SETUP) || (state == S_STROBE) || (state == S_HOLD);
  assign req_ready = (state == S_IDLE) && tick;
  assign rsp_rdata = rdata_q;

  always_comb
    for (int i = 0; i < NB; i++)
      mem_sel_n[i] = !(busy && bank_q == BW'(i));

  assign mem_rd   = (state == S_STROBE && !we_q) ? cfg_rd_pol : !cfg_rd_pol;
  assign mem_wr   = (state == S_STROBE && we_q)  ? cfg_wr_pol : !cfg_wr_pol;
  assign mem_oe   = busy && we_q;
  assign mem_addr = cfg_bus8 ? {addr_q, byte_q} : {1'b0, addr_q};
  assign mem_dout = cfg_bus8 ? {8'h00, byte_q ? wdata_q[15:8] : wdata_q[7:0]} : wdata_q;

  assert_sel_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~mem_sel_n));
  assert_strobe_has_sel_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ((mem_rd == cfg_rd_pol) || (mem_wr == cfg_wr_pol)) |-> !(&mem_sel_n));
  assert_miss_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (rsp_rdata == 16'h0000));
  assert_tick_gates_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(state));
  assert_no_dual_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !((mem_rd == cfg_rd_pol) && (mem_wr == cfg_wr_pol)));
  assert_rsp_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  assert_ready_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (&mem_sel_n));
endmodule

// File: tb/ext_bus_ctrl_bench.sv
module ext_bus_ctrl_bench;
  localparam int AW = 16, WW = 4, NB = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic req_valid = 1'b0, req_we = 1'b0, req_ready, rsp_valid, rsp_err;
  logic [AW-1:0] req_addr = '0;
  logic [15:0] req_wdata = '0, rsp_rdata, mem_dout, mem_din;
  logic [NB*AW-1:0] cfg_lo, cfg_hi;
  logic [NB*WW-1:0] cfg_rd_wait, cfg_wr_wait;
  logic [NB*2-1:0] cfg_mode;
  logic [2:0] cfg_div = 3'd0;
  logic cfg_bus8 = 1'b0, cfg_rd_pol = 1'b1, cfg_wr_pol = 1'b1;
  logic [NB-1:0] mem_sel_n;
  logic [AW:0] mem_addr;
  logic mem_rd, mem_wr, mem_oe, mem_ack = 1'b0;

  localparam logic [1:0] BMODE [4] = '{2'b00, 2'b01, 2'b10, 2'b11};
  localparam int BRD [4] = '{2, 0, 3, 4};
  localparam int BWR [4] = '{1, 0, 3, 2};
  assign cfg_lo = {16'h2800, 16'h2000, 16'h1000, 16'h0000};
  assign cfg_hi = {16'h3FFF, 16'h2FFF, 16'h1FFF, 16'h0FFF};
  assign cfg_rd_wait = {4'd4, 4'd3, 4'd0, 4'd2};
  assign cfg_wr_wait = {4'd2, 4'd3, 4'd0, 4'd1};
  assign cfg_mode = {2'b11, 2'b10, 2'b01, 2'b00};

  function automatic logic [15:0] wf(input logic [15:0] a); return a ^ 16'hA5C3; endfunction
  function automatic logic [7:0] bf(input logic [16:0] a); return a[7:0] ^ 8'h5A ^ {a[16:13], 4'h0}; endfunction
  assign mem_din = cfg_bus8 ? {8'h00, bf(mem_addr)} : wf(mem_addr[15:0]);

  ext_bus_ctrl #(.AW(AW), .WW(WW), .NB(NB)) u_ext_bus_ctrl (.*);

  int checks = 0, fails = 0, ackd = 99, stb_cnt = 0, n_start = 0;
  bit any_sel = 0, prev_act = 0, done_flag = 0;
  logic [NB-1:0] log_sel [4];
  logic [AW:0]   log_addr [4];
  logic [15:0]   log_data [4];

  always @(negedge clk) begin
    automatic bit act = (mem_rd === cfg_rd_pol) || (mem_wr === cfg_wr_pol);
    if (rst_n) begin
      if (!(&mem_sel_n)) any_sel = 1;
      if (act && !prev_act && n_start < 4) begin
        log_sel[n_start] = mem_sel_n; log_addr[n_start] = mem_addr; log_data[n_start] = mem_dout;
        n_start++;
      end
      stb_cnt = act ? stb_cnt + 1 : 0;
      mem_ack = (stb_cnt >= ackd);
      prev_act = act;
    end
  end

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic finish_run;
    if (!done_flag) begin
      done_flag = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  typedef struct packed {
    logic we; logic [15:0] addr; logic b8; logic [2:0] div; logic [7:0] ackd;
    logic rp; logic wp; logic [2:0] bank;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 16'h0010, 1'b0, 3'd0, 8'd99, 1'b1, 1'b1, 3'd0},
    '{1'b1, 16'h0020, 1'b0, 3'd0, 8'd99, 1'b1, 1'b1, 3'd0},
    '{1'b0, 16'h0010, 1'b0, 3'd0, 8'd1,  1'b1, 1'b1, 3'd0},
    '{1'b0, 16'h1004, 1'b0, 3'd0, 8'd3,  1'b1, 1'b1, 3'd1},
    '{1'b1, 16'h1008, 1'b0, 3'd0, 8'd5,  1'b1, 1'b1, 3'd1},
    '{1'b0, 16'h2004, 1'b0, 3'd0, 8'd2,  1'b1, 1'b1, 3'd2},
    '{1'b0, 16'h2004, 1'b0, 3'd0, 8'd6,  1'b1, 1'b1, 3'd2},
    '{1'b0, 16'h3000, 1'b0, 3'd0, 8'd2,  1'b1, 1'b1, 3'd3},
    '{1'b0, 16'h3000, 1'b0, 3'd0, 8'd9,  1'b1, 1'b1, 3'd3},
    '{1'b0, 16'h2900, 1'b0, 3'd0, 8'd2,  1'b1, 1'b1, 3'd2},
    '{1'b0, 16'h0100, 1'b1, 3'd0, 8'd99, 1'b1, 1'b1, 3'd0},
    '{1'b1, 16'h0101, 1'b1, 3'd0, 8'd99, 1'b1, 1'b1, 3'd0},
    '{1'b0, 16'h1010, 1'b1, 3'd0, 8'd2,  1'b1, 1'b1, 3'd1},
    '{1'b0, 16'h0010, 1'b0, 3'd1, 8'd99, 1'b1, 1'b1, 3'd0},
    '{1'b0, 16'h0010, 1'b0, 3'd2, 8'd99, 1'b1, 1'b1, 3'd0},
    '{1'b0, 16'h0010, 1'b0, 3'd3, 8'd99, 1'b1, 1'b1, 3'd0},
    '{1'b0, 16'h0010, 1'b0, 3'd4, 8'd99, 1'b1, 1'b1, 3'd0},
    '{1'b0, 16'h5000, 1'b0, 3'd0, 8'd99, 1'b1, 1'b1, 3'd4},
    '{1'b0, 16'h5000, 1'b0, 3'd3, 8'd99, 1'b1, 1'b1, 3'd4},
    '{1'b1, 16'h4000, 1'b0, 3'd0, 8'd99, 1'b1, 1'b1, 3'd4},
    '{1'b0, 16'h0010, 1'b0, 3'd0, 8'd99, 1'b0, 1'b0, 3'd0},
    '{1'b1, 16'h0020, 1'b0, 3'd0, 8'd99, 1'b0, 1'b0, 3'd0},
    '{1'b1, 16'h2008, 1'b1, 3'd0, 8'd2,  1'b0, 1'b1, 3'd2}
  };

  function automatic int ratio_of(input logic [2:0] d);
    case (d) 3'd1: return 2; 3'd2: return 4; 3'd3: return 16; 3'd4: return 32; default: return 1; endcase
  endfunction

  function automatic int exp_lat(input vec_t v);
    int w, jc, ja, j;
    if (v.bank == 3'd4) return ratio_of(v.div);
    w  = v.we ? BWR[v.bank] : BRD[v.bank];
    jc = w + 1;
    ja = v.ackd;
    case (BMODE[v.bank])
      2'b00: j = jc;
      2'b01: j = ja;
      2'b10: j = (jc > ja) ? jc : ja;
      default: j = (jc < ja) ? jc : ja;
    endcase
    return (j + 2) * ratio_of(v.div) * (v.b8 ? 2 : 1);
  endfunction

  task automatic run(input vec_t v);
    int cyc, guard, exp_k;
    string rq;
    logic [15:0] wd, exp_rd;
    bit miss = (v.bank == 3'd4);
    @(negedge clk);
    cfg_div = v.div; cfg_bus8 = v.b8; cfg_rd_pol = v.rp; cfg_wr_pol = v.wp; ackd = v.ackd;
    wd = v.addr ^ 16'h1357;
    req_we = v.we; req_addr = v.addr; req_wdata = wd;
    n_start = 0; any_sel = 0;
    @(negedge clk);
    chk(mem_rd == !v.rp && mem_wr == !v.wp, "R8", "idle strobe levels", {mem_rd, mem_wr}, {!v.rp, !v.wp});
    req_valid = 1'b1;
    guard = 0;
    while (!req_ready && guard < 100) begin @(negedge clk); guard++; end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R9", "ready low while busy", req_ready, 0);
    cyc = 0;
    while (!rsp_valid && cyc < 2000) begin @(negedge clk); cyc++; end
    exp_k = exp_lat(v);
    rq = miss ? "R2" : (v.div != 0) ? "R5" : (BMODE[v.bank] != 2'b00) ? "R4" : "R3";
    chk(cyc == exp_k, rq, "latency", cyc, exp_k);
    chk(rsp_err == miss, miss ? "R2" : "R1", "error flag", rsp_err, miss);
    if (miss) begin
      chk(!any_sel && n_start == 0, "R2", "no select or strobe", {any_sel, 8'(n_start)}, 0);
      chk(rsp_rdata == 16'h0, "R2", "miss read data", rsp_rdata, 0);
    end else begin
      chk(n_start == (v.b8 ? 2 : 1), v.b8 ? "R7" : "R6", "strobe count", n_start, v.b8 ? 2 : 1);
      chk(log_sel[0] == ~(4'b0001 << v.bank), "R1", "select", log_sel[0], ~(4'b0001 << v.bank));
      if (v.we) begin
        if (v.b8) begin
          chk(log_addr[0] == {v.addr, 1'b0} && log_data[0] == {8'h00, wd[7:0]}, "R7", "first byte write",
              {log_addr[0], log_data[0]}, {v.addr, 1'b0, 8'h00, wd[7:0]});
          chk(log_addr[1] == {v.addr, 1'b1} && log_data[1] == {8'h00, wd[15:8]}, "R7", "second byte write",
              {log_addr[1], log_data[1]}, {v.addr, 1'b1, 8'h00, wd[15:8]});
        end else
          chk(log_addr[0] == {1'b0, v.addr} && log_data[0] == wd, "R6", "word write",
              {log_addr[0], log_data[0]}, {1'b0, v.addr, wd});
      end else begin
        exp_rd = v.b8 ? {bf({v.addr, 1'b1}), bf({v.addr, 1'b0})} : wf(v.addr);
        chk(rsp_rdata == exp_rd, v.b8 ? "R7" : "R6", "read data", rsp_rdata, exp_rd);
      end
    end
    @(negedge clk);
    chk(!rsp_valid, "R9", "response pulse width", rsp_valid, 0);
  endtask

  initial begin
    #(8 * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(mem_sel_n == 4'hF, "R10", "selects in reset", mem_sel_n, 4'hF);
    chk(mem_rd == 1'b0 && mem_wr == 1'b0, "R10", "strobes in reset", {mem_rd, mem_wr}, 0);
    chk(!rsp_valid, "R10", "rsp_valid in reset", rsp_valid, 0);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) run(VEC[i]);
    finish_run();
  end
endmodule